// File: doc/BRIEF.md
# Subword Mix and Permute Unit

This block rearranges the 16-bit lanes of a 64-bit datapath word. It takes two source operands, X and Y, and a 3-bit operation code, and it forms one result word. Four of the operations interleave lanes from both sources. They take either the even or the odd lanes of X and Y, or they join the left or right 32-bit halves of X and Y. The fifth operation is a one-source permute: an 8-bit selector chooses, for each result lane, which lane of X feeds it. With this permute one lane can be copied into every position, the lane order can be reversed, or the lanes can be placed in any other order.

The unit is a building block for media loops. Eight of its mix operations transpose a 4x4 halfword matrix in two passes. Mixing a register with a zero register widens 16-bit values into 32-bit lanes. The result is computed in one level of multiplexing. A parameter chooses between a registered output with one cycle of latency and a purely combinational output.

Top module: `subword_shuffle`

## Requirements
- R1: Lanes are numbered 0 to 3, with lane 0 in bits [63:48] and lane 3 in bits [15:0]. Op code 0 (even interleave) gives {x0, y0, x2, y2}.
- R2: Op code 1 (odd interleave) gives {x1, y1, x3, y3}.
- R3: Op code 2 (left-half join) gives {x0, x1, y0, y1}.
- R4: Op code 3 (right-half join) gives {x2, x3, y2, y3}.
- R5: Op code 4 (permute) fills result lane k from the X lane whose number is held in selector bits [2k+1:2k]. Selector 8'hE4 returns X unchanged. Y has no effect on the permute result.
- R6: A permute selector whose four fields are all equal copies that one X lane into all four result lanes. Selector 8'h1B reverses the lane order.
- R7: Op codes 5, 6 and 7 give an all-zero result.
- R8: Op codes 0 and 1 with Y equal to zero put X's chosen lanes in lanes 0 and 2 of the result and zeros in lanes 1 and 3.
- R9: Four interleave operations on row pairs, followed by four half-join operations on their results, give the transpose of a 4x4 halfword matrix.
- R10: With the registered output, the result appears on the first rising clock edge after the inputs are applied. An active-low asynchronous reset clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 to 4 valid, 5 to 7 give zero) |
| sel_i | input | 8 | Permute selector, 2 bits per result lane |
| src_x_i | input | 64 | Source operand X |
| src_y_i | input | 64 | Source operand Y |
| res_o | output | 64 | Rearranged result |

## Verification
Each lane of both sources carries a distinct value, so a result shows exactly where every lane came from. This separates even from odd selection, left from right halves, and X from Y. The permute is tried with the identity, reversal, broadcast and a scrambled selector, and it is then repeated with a different Y to show that Y is ignored. Two further patterns use a zero Y to check lane widening. A row matrix whose elements encode their own row and column is pushed through the eight-step transpose, so that any misplaced element names its wrong position. The unused op codes are fed with non-zero sources to show that they force zero.

// File: rtl/subword_pkg.sv
package subword_pkg;
    localparam int LANES   = 4;
    localparam int IDX_W   = $clog2(LANES);
    localparam int SEL_W   = IDX_W * LANES;

    typedef enum logic [2:0] {
        OP_EVEN  = 3'd0,
        OP_ODD   = 3'd1,
        OP_LEFT  = 3'd2,
        OP_RIGHT = 3'd3,
        OP_PERM  = 3'd4
    } shuf_op_e;
endpackage

// File: rtl/lane_interleave.sv
module lane_interleave
    import subword_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W*LANES-1:0] a_i,
    input  logic [LANE_W*LANES-1:0] b_i,
    output logic [LANE_W*LANES-1:0] even_o,
    output logic [LANE_W*LANES-1:0] odd_o,
    output logic [LANE_W*LANES-1:0] left_o,
    output logic [LANE_W*LANES-1:0] right_o
);
    localparam int DW   = LANE_W * LANES;
    localparam int HALF = LANES / 2;

    // lane k occupies the slice starting at DW-1-k*LANE_W
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        localparam int LO = DW - 1 - (2*p)     * LANE_W;
        localparam int HI = DW - 1 - (2*p + 1) * LANE_W;
        localparam int LP = DW - 1 - p          * LANE_W;
        localparam int RP = DW - 1 - (p + HALF) * LANE_W;
        assign even_o[LO -: LANE_W]  = a_i[LO -: LANE_W];
        assign even_o[HI -: LANE_W]  = b_i[LO -: LANE_W];
        assign odd_o[LO -: LANE_W]   = a_i[HI -: LANE_W];
        assign odd_o[HI -: LANE_W]   = b_i[HI -: LANE_W];
        assign left_o[LP -: LANE_W]  = a_i[LP -: LANE_W];
        assign left_o[RP -: LANE_W]  = b_i[LP -: LANE_W];
        assign right_o[LP -: LANE_W] = a_i[RP -: LANE_W];
        assign right_o[RP -: LANE_W] = b_i[RP -: LANE_W];
    end

    // R1/R3: both left-leaning forms start with lane 0 of a_i
    always_comb begin
        assert_even_left_lane0_R1:
            assert (even_o[DW-1 -: LANE_W] == left_o[DW-1 -: LANE_W]);
        // R2/R4: odd lane 2 and right lane 1 both carry x3
        assert_odd_right_x3_R2:
            assert (odd_o[DW-1-2*LANE_W -: LANE_W] == right_o[DW-1-LANE_W -: LANE_W]);
        // R3/R2: left lane 1 and odd lane 0 both carry x1
        assert_left_odd_x1_R3:
            assert (left_o[DW-1-LANE_W -: LANE_W] == odd_o[DW-1 -: LANE_W]);
    end
endmodule

// File: rtl/lane_permute.sv
module lane_permute
    import subword_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W*LANES-1:0] src_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [LANE_W*LANES-1:0] res_o
);
    localparam int DW = LANE_W * LANES;

    logic [LANE_W-1:0] lane_in [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_in[k] = src_i[DW-1-k*LANE_W -: LANE_W];
        assign res_o[DW-1-k*LANE_W -: LANE_W] = lane_in[sel_i[IDX_W*k +: IDX_W]];
    end

    // R6: equal selector fields broadcast one lane everywhere
    always_comb begin
        if (sel_i[1:0] == sel_i[3:2] && sel_i[3:2] == sel_i[5:4]
            && sel_i[5:4] == sel_i[7:6])
            assert_broadcast_equal_R6:
                assert (res_o[DW-1 -: LANE_W] == res_o[LANE_W-1:0]);
    end
endmodule

// File: rtl/subword_shuffle.sv
module subword_shuffle
    import subword_pkg::*;
#(
    parameter int LANE_W  = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              op_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [LANE_W*LANES-1:0] src_x_i,
    input  logic [LANE_W*LANES-1:0] src_y_i,
    output logic [LANE_W*LANES-1:0] res_o
);
    localparam int DW = LANE_W * LANES;

    typedef struct packed {
        logic [DW-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] even_w, odd_w, left_w, right_w, perm_w;

    lane_interleave #(.LANE_W(LANE_W)) u_mix (
        .a_i     (src_x_i),
        .b_i     (src_y_i),
        .even_o  (even_w),
        .odd_o   (odd_w),
        .left_o  (left_w),
        .right_o (right_w)
    );

    lane_permute #(.LANE_W(LANE_W)) u_perm (
        .src_i (src_x_i),
        .sel_i (sel_i),
        .res_o (perm_w)
    );

    always_comb begin
        st_d = '0;
        case (shuf_op_e'(op_i))
            OP_EVEN:  st_d.res = even_w;
            OP_ODD:   st_d.res = odd_w;
            OP_LEFT:  st_d.res = left_w;
            OP_RIGHT: st_d.res = right_w;
            OP_PERM:  st_d.res = perm_w;
            default:  st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (REG_OUT) begin : g_reg
        assign res_o = st_q.res;

        assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i > 3'd4) |=> (res_o == '0));

        assert_identity_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd4 && sel_i == 8'hE4) |=> (res_o == $past(src_x_i)));

        assert_zero_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i <= 3'd1 && src_y_i == '0) |=>
            (res_o[DW-1-LANE_W -: LANE_W] == '0 && res_o[LANE_W-1:0] == '0));

        assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd0) |=> (res_o[DW-1 -: LANE_W] == $past(src_x_i[DW-1 -: LANE_W])));
    end else begin : g_comb
        assign res_o = st_d.res;
    end
endmodule

// File: tb/sim_subword_shuffle.sv
module sim_subword_shuffle;
    localparam int N = 10;
    localparam logic [63:0] XA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] YA = 64'hAAAA_BBBB_CCCC_DDDD;

    localparam logic [2:0]  V_OP  [N] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4,
                                         3'd4, 3'd4, 3'd4, 3'd5, 3'd7};
    localparam logic [7:0]  V_SEL [N] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hE4,
                                         8'h1B, 8'h55, 8'h2D, 8'hFF, 8'h1B};
    localparam int          V_REQ [N] = '{1, 2, 3, 4, 5, 6, 6, 5, 7, 7};
    localparam logic [63:0] V_EXP [N] = '{
        64'h1111_AAAA_3333_CCCC,   // R1
        64'h2222_BBBB_4444_DDDD,   // R2
        64'h1111_2222_AAAA_BBBB,   // R3
        64'h3333_4444_CCCC_DDDD,   // R4
        64'h1111_2222_3333_4444,   // R5 identity
        64'h4444_3333_2222_1111,   // R6 reverse
        64'h2222_2222_2222_2222,   // R6 broadcast lane 1
        64'h2222_4444_3333_1111,   // R5 scrambled
        64'h0000_0000_0000_0000,   // R7
        64'h0000_0000_0000_0000};  // R7

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  sel = 8'h00;
    logic [63:0] x = 64'h0;
    logic [63:0] y = 64'h0;
    logic [63:0] res;
    int total = 0;
    int bad = 0;
    logic [63:0] t1, t2, u1, u2, got;
    logic [63:0] rows [4];

    always #10 clk = ~clk;

    subword_shuffle u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .sel_i(sel),
        .src_x_i(x), .src_y_i(y), .res_o(res)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] o, input logic [7:0] s,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r);
        @(negedge clk);
        op = o; sel = s; x = a; y = b;
        @(negedge clk);
        r = res;
    endtask

    initial begin
        #5000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        x = XA; y = YA; op = 3'd0;
        repeat (3) @(negedge clk);
        check("R10 reset", res, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            run(V_OP[i], V_SEL[i], XA, YA, got);
            check($sformatf("R%0d vec%0d", V_REQ[i], i), got, V_EXP[i]);
        end

        // R5: Y has no effect on permute
        run(3'd4, 8'h2D, XA, 64'h5A5A_0F0F_F0F0_A5A5, got);
        check("R5 y ignored", got, 64'h2222_4444_3333_1111);
        // R7: op code 6 also zero
        run(3'd6, 8'hE4, XA, YA, got);
        check("R7 op6", got, 64'h0);

        // R8: widening with a zero source
        run(3'd0, 8'h00, 64'h8001_7FFE_FFFF_0123, 64'h0, got);
        check("R8 even", got, 64'h8001_0000_FFFF_0000);
        run(3'd1, 8'h00, 64'h8001_7FFE_FFFF_0123, 64'h0, got);
        check("R8 odd", got, 64'h7FFE_0000_0123_0000);

        // R10: one-cycle latency, output holds old value until edge
        @(negedge clk);
        op = 3'd3; x = XA; y = YA;
        #1;
        check("R10 before edge", res, 64'h7FFE_0000_0123_0000);
        @(negedge clk);
        check("R10 after edge", res, 64'h3333_4444_CCCC_DDDD);

        // R9: 4x4 transpose, element (i,k) = {i+1,k+1}
        for (int i = 0; i < 4; i++)
            for (int k = 0; k < 4; k++)
                rows[i][63-16*k -: 16] = 16'(((i + 1) << 4) | (k + 1));
        run(3'd0, 8'h00, rows[0], rows[1], t1);
        run(3'd1, 8'h00, rows[0], rows[1], t2);
        run(3'd0, 8'h00, rows[2], rows[3], u1);
        run(3'd1, 8'h00, rows[2], rows[3], u2);
        for (int c = 0; c < 4; c++) begin
            logic [63:0] col;
            for (int i = 0; i < 4; i++)
                col[63-16*i -: 16] = 16'(((i + 1) << 4) | (c + 1));
            case (c)
                0: run(3'd2, 8'h00, t1, u1, got);
                1: run(3'd2, 8'h00, t2, u2, got);
                2: run(3'd3, 8'h00, t1, u1, got);
                default: run(3'd3, 8'h00, t2, u2, got);
            endcase
            check($sformatf("R9 column %0d", c), got, col);
        end

        // R10: asynchronous reset clears the result
        @(negedge clk);
        op = 3'd2;
        @(negedge clk);
        #3 rst_n = 1'b0;
        #1;
        check("R10 async clear", res, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule